// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo audio stream into parallel samples. A bit clock, a frame clock and a data line arrive as plain inputs sampled by the system clock. The receiver samples the data line on every rising bit-clock edge. It watches the frame clock for the half-frame boundary and, at each boundary, presents the word of the channel that has just ended as a 24-bit sample with a one-cycle strobe.

A 3-bit format code picks the framing. The first choice is the classic I2S framing, with a one-bit delay after the frame-clock change and a low frame clock for the left channel. The second is left-justified framing, where the MSB comes right after the change. The third is right-justified framing, where the LSB sits just before the change, with a word width of 16, 18, 20 or 24 bits. Words in the two MSB-aligned framings come out left-aligned. Right-justified words come out sign-extended. The bit clock and frame clock must be synchronous to, and much slower than, the system clock: at least two system clocks in each bit-clock phase.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, both samples read zero and both strobes stay low until a word is reported.
- R2: Format codes 0 and 1 select I2S framing. Sampling is on rising bit-clock edges. The first rising edge at or after a frame-clock change holds no data. The MSB is taken on the second edge and up to 24 bits follow, MSB first. A half-frame with the frame clock low is the left channel.
- R3: Format codes 2 and 7 select left-justified framing. The MSB is taken on the first rising edge at or after the frame-clock change, and up to 24 bits follow. A half-frame with the frame clock high is the left channel.
- R4: Format codes 3, 4, 5 and 6 select right-justified framing with word widths of 24, 20, 18 and 16 bits. The LSB is the bit taken on the last rising edge before the frame-clock change. The sample is the word sign-extended from its top bit to 24 bits. A frame-clock high half-frame is the left channel.
- R5: In the two MSB-aligned framings, a half-frame with fewer than 24 data slots gives a left-aligned sample padded with zeros below. Data slots beyond the 24th are ignored.
- R6: A channel's word is reported when the bit-clock rising edge of the next half-frame's first slot is seen. Its sample and strobe change on the first system-clock edge that sees that bit clock high. The strobe is high for one system-clock cycle, and the left and right strobes are never high together.
- R7: The half-frame that is in progress when reset is released is never reported, because its start was not seen.
- R8: Each sample output holds its value between its own strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Framing and word-width code; hold steady while a stream is running |
| sclk | input | 1 | Serial bit clock, synchronous to clk |
| lrck | input | 1 | Frame clock selecting the channel |
| sdata | input | 1 | Serial audio data |
| left_sample | output | 24 | Last left-channel sample |
| left_strobe | output | 1 | One-cycle pulse when left_sample is updated |
| right_sample | output | 24 | Last right-channel sample |
| right_strobe | output | 1 | One-cycle pulse when right_sample is updated |

## Verification
Each result is due in the single system-clock cycle after the first clock edge that sees the bit clock high at the start of the next half-frame. The strobe is high only in that cycle, and the sample keeps its new value from then on. The bench changes bit clock, frame clock and data only on falling clock edges. It keeps a behavioural model that holds the sampled bits of the current half-frame in a queue and works out the expected sample at each boundary. On every falling edge the bench compares all four outputs with the values the model expects for that cycle, so a strobe that comes one cycle early or late fails, and so does a sample that changes when it should hold.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        FK_I2S   = 2'd0,
        FK_LEFT  = 2'd1,
        FK_RIGHT = 2'd2
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e kind;
        logic [4:0]  rj_bits;
    } frame_cfg_t;

    // Map the 3-bit code onto framing and right-justified width.
    function automatic frame_cfg_t decode_fmt(input logic [2:0] code);
        frame_cfg_t c;
        c.kind    = FK_LEFT;
        c.rj_bits = 5'd24;
        case (code)
            3'd0, 3'd1: c.kind = FK_I2S;
            3'd2, 3'd7: c.kind = FK_LEFT;
            3'd3: begin c.kind = FK_RIGHT; c.rj_bits = 5'd24; end
            3'd4: begin c.kind = FK_RIGHT; c.rj_bits = 5'd20; end
            3'd5: begin c.kind = FK_RIGHT; c.rj_bits = 5'd18; end
            3'd6: begin c.kind = FK_RIGHT; c.rj_bits = 5'd16; end
            default: c.kind = FK_LEFT;
        endcase
        return c;
    endfunction

    // Frame-clock level that marks the left channel depends on framing.
    function automatic logic is_left_half(input frame_kind_e kind, input logic lr);
        return (kind == FK_I2S) ? ~lr : lr;
    endfunction

endpackage

// File: rtl/sar_edge_track.sv
module sar_edge_track #(
    parameter int CNT_W   = 5,
    parameter int POS_SAT = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             lrck_i,
    output logic             rise_o,
    output logic             boundary_o,
    output logic             emit_o,
    output logic             prev_lr_o,
    output logic [CNT_W-1:0] pos_o
);

    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(POS_SAT);

    typedef struct packed {
        logic             sclk;
        logic             primed;
        logic             armed;
        logic             prev_lr;
        logic [CNT_W-1:0] pos;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.sclk = sclk_i;
        rise_o     = sclk_i & ~trk_q.sclk;
        boundary_o = rise_o & trk_q.primed & (lrck_i != trk_q.prev_lr);
        emit_o     = boundary_o & trk_q.armed;
        prev_lr_o  = trk_q.prev_lr;
        if (boundary_o) begin
            pos_o = '0;
        end else if (trk_q.pos != SAT_C) begin
            pos_o = trk_q.pos + 1'b1;
        end else begin
            pos_o = trk_q.pos;
        end
        if (rise_o) begin
            trk_d.primed  = 1'b1;
            trk_d.prev_lr = lrck_i;
            trk_d.pos     = pos_o;
            if (boundary_o) begin
                trk_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // R7
    no_emit_before_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_o) |-> (trk_q.primed && trk_q.armed));

endmodule

// File: rtl/sar_shifter.sv
module sar_shifter
    import sar_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              boundary_i,
    input  logic [CNT_W-1:0]  pos_i,
    input  logic              bit_i,
    input  frame_cfg_t        cfg_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  nbits_o
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [CNT_W-1:0]  n;
    } shf_t;

    shf_t shf_d, shf_q;
    logic take;

    always_comb begin
        case (cfg_i.kind)
            FK_RIGHT: take = 1'b1;
            FK_LEFT:  take = (pos_i < FULL_C);
            default:  take = (pos_i != '0) && (pos_i <= FULL_C);
        endcase
    end

    always_comb begin
        shf_d = shf_q;
        if (rise_i) begin
            if (boundary_i) begin
                shf_d.sr = take ? {{(WORD_W-1){1'b0}}, bit_i} : '0;
                shf_d.n  = take ? CNT_W'(1) : '0;
            end else if (take) begin
                shf_d.sr = {shf_q.sr[WORD_W-2:0], bit_i};
                shf_d.n  = (shf_q.n == FULL_C) ? FULL_C : shf_q.n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign word_o  = shf_q.sr;
    assign nbits_o = shf_q.n;

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shf_q.n <= FULL_C);

    // R2
    i2s_delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && cfg_i.kind == FK_I2S) |=> (shf_q.n == '0));

    // R3
    lj_first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && cfg_i.kind == FK_LEFT) |=> (shf_q.n == CNT_W'(1) && shf_q.sr[0] == $past(bit_i)));

endmodule

// File: rtl/sar_formatter.sv
module sar_formatter
    import sar_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_i,
    input  logic              left_i,
    input  frame_cfg_t        cfg_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  nbits_i,
    output logic [WORD_W-1:0] l_data_o,
    output logic              l_valid_o,
    output logic [WORD_W-1:0] r_data_o,
    output logic              r_valid_o
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] l_data;
        logic              l_valid;
        logic [WORD_W-1:0] r_data;
        logic              r_valid;
    } out_t;

    out_t out_d, out_q;
    logic [WORD_W-1:0] shaped;
    logic              sign_b;

    always_comb begin
        sign_b = word_i[cfg_i.rj_bits - 5'd1];
        shaped = '0;
        if (cfg_i.kind == FK_RIGHT) begin
            for (int i = 0; i < WORD_W; i++) begin
                shaped[i] = (i < int'(cfg_i.rj_bits)) ? word_i[i] : sign_b;
            end
        end else begin
            shaped = word_i << (FULL_C - nbits_i);
        end
    end

    always_comb begin
        out_d         = out_q;
        out_d.l_valid = 1'b0;
        out_d.r_valid = 1'b0;
        if (emit_i) begin
            if (left_i) begin
                out_d.l_data  = shaped;
                out_d.l_valid = 1'b1;
            end else begin
                out_d.r_data  = shaped;
                out_d.r_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign l_data_o  = out_q.l_data;
    assign l_valid_o = out_q.l_valid;
    assign r_data_o  = out_q.r_data;
    assign r_valid_o = out_q.r_valid;

    // R4
    rj16_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.l_valid && $past(cfg_i.kind == FK_RIGHT && cfg_i.rj_bits == 5'd16))
        |-> ((&out_q.l_data[WORD_W-1:15]) || !(|out_q.l_data[WORD_W-1:15])));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fmt_sel,
    input  logic              sclk,
    input  logic              lrck,
    input  logic              sdata,
    output logic [WORD_W-1:0] left_sample,
    output logic              left_strobe,
    output logic [WORD_W-1:0] right_sample,
    output logic              right_strobe
);

    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int POS_SAT = WORD_W + 1;

    frame_cfg_t        cfg;
    logic              rise, boundary, emit, prev_lr, ending_left;
    logic [CNT_W-1:0]  pos, nbits;
    logic [WORD_W-1:0] word;

    assign cfg         = decode_fmt(fmt_sel);
    assign ending_left = is_left_half(cfg.kind, prev_lr);

    sar_edge_track #(.CNT_W(CNT_W), .POS_SAT(POS_SAT)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .lrck_i     (lrck),
        .rise_o     (rise),
        .boundary_o (boundary),
        .emit_o     (emit),
        .prev_lr_o  (prev_lr),
        .pos_o      (pos)
    );

    sar_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .boundary_i (boundary),
        .pos_i      (pos),
        .bit_i      (sdata),
        .cfg_i      (cfg),
        .word_o     (word),
        .nbits_o    (nbits)
    );

    sar_formatter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit_i    (emit),
        .left_i    (ending_left),
        .cfg_i     (cfg),
        .word_i    (word),
        .nbits_i   (nbits),
        .l_data_o  (left_sample),
        .l_valid_o (left_strobe),
        .r_data_o  (right_sample),
        .r_valid_o (right_strobe)
    );

    // R6
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({left_strobe, right_strobe}));

    // R6
    left_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_strobe |=> !left_strobe);

    // R6
    right_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        right_strobe |=> !right_strobe);

    // R8
    left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !left_strobe |-> $stable(left_sample));

    // R8
    right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !right_strobe |-> $stable(right_sample));

endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_r = 3'd0;
    logic        sclk_r = 1'b0;
    logic        lrck_r = 1'b0;
    logic        sdata_r = 1'b0;
    logic [23:0] l_smp, r_smp;
    logic        l_stb, r_stb;

    always #5 clk = ~clk;

    serial_audio_rx i_serial_audio_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .fmt_sel      (fmt_r),
        .sclk         (sclk_r),
        .lrck         (lrck_r),
        .sdata        (sdata_r),
        .left_sample  (l_smp),
        .left_strobe  (l_stb),
        .right_sample (r_smp),
        .right_strobe (r_stb)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    bit    finished = 1'b0;

    logic [23:0] exp_ld = '0, exp_rd = '0;
    logic        exp_lv = 1'b0, exp_rv = 1'b0;

    // behavioural model state
    bit   m_primed, m_armed;
    logic m_prev;
    logic q_bits[$];

    task automatic tick();
        @(negedge clk);
        n_checks++;
        if (l_stb !== exp_lv || r_stb !== exp_rv) begin
            n_fails++;
            $display("FAIL R6 (%s) strobes L/R actual %b%b expected %b%b at %0t",
                     cur_req, l_stb, r_stb, exp_lv, exp_rv, $time);
        end
        if (l_smp !== exp_ld) begin
            n_fails++;
            $display("FAIL %s R8 left_sample actual %h expected %h at %0t",
                     cur_req, l_smp, exp_ld, $time);
        end
        if (r_smp !== exp_rd) begin
            n_fails++;
            $display("FAIL %s R8 right_sample actual %h expected %h at %0t",
                     cur_req, r_smp, exp_rd, $time);
        end
        exp_lv = 1'b0;
        exp_rv = 1'b0;
    endtask

    function automatic int rj_width(input logic [2:0] f);
        if (f == 3'd3) return 24;
        if (f == 3'd4) return 20;
        if (f == 3'd5) return 18;
        if (f == 3'd6) return 16;
        return 0;
    endfunction

    function automatic bit is_i2s(input logic [2:0] f);
        return (f == 3'd0 || f == 3'd1);
    endfunction

    function automatic logic [23:0] model_word();
        logic [23:0] w = '0;
        int wid = rj_width(fmt_r);
        int qs = q_bits.size();
        if (wid != 0) begin
            for (int i = 0; i < 24; i++) begin
                int k = (i < wid) ? i : wid - 1;
                w[i] = (k < qs) ? q_bits[qs-1-k] : 1'b0;
            end
        end else begin
            int off = is_i2s(fmt_r) ? 1 : 0;
            for (int i = 0; i < 24; i++) begin
                w[23-i] = (i + off < qs) ? q_bits[i+off] : 1'b0;
            end
        end
        return w;
    endfunction

    task automatic model_rise(input logic lv, input logic b);
        if (!m_primed) begin
            m_primed = 1'b1;
        end else if (lv != m_prev) begin
            if (m_armed) begin
                bit left_end = is_i2s(fmt_r) ? (m_prev == 1'b0) : (m_prev == 1'b1);
                if (left_end) begin exp_ld = model_word(); exp_lv = 1'b1; end
                else          begin exp_rd = model_word(); exp_rv = 1'b1; end
            end
            m_armed = 1'b1;
            q_bits.delete();
        end
        q_bits.push_back(b);
        m_prev = lv;
    endtask

    task automatic sclk_bit(input logic lv, input logic b);
        sclk_r  = 1'b0;
        lrck_r  = lv;
        sdata_r = b;
        tick();
        tick();
        sclk_r = 1'b1;
        model_rise(lv, b);
        tick();
        tick();
    endtask

    // one half-frame; word is right-aligned in wlen bits, fill goes in the unused slots
    task automatic play_half(input logic lv, input int slots, input logic [23:0] word,
                             input int wlen, input logic fill);
        for (int s = 0; s < slots; s++) begin
            int idx;
            logic b;
            if (rj_width(fmt_r) != 0) idx = s - (slots - wlen);
            else if (is_i2s(fmt_r))   idx = s - 1;
            else                      idx = s;
            b = (idx >= 0 && idx < wlen) ? word[wlen-1-idx] : fill;
            sclk_bit(lv, b);
        end
    endtask

    task automatic do_reset(input logic [2:0] f);
        rst_n  = 1'b0;
        sclk_r = 1'b0;
        fmt_r  = f;
        exp_ld = '0; exp_rd = '0; exp_lv = 1'b0; exp_rv = 1'b0;
        m_primed = 1'b0; m_armed = 1'b0; m_prev = 1'b0;
        q_bits.delete();
        cur_req = "R1";
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic run_case(input logic [2:0] f, input string req, input int slots,
                            input int wlen, input logic fill, input int frames);
        logic left_lv = is_i2s(f) ? 1'b0 : 1'b1;
        logic [23:0] mask = (wlen >= 24) ? 24'hFFFFFF : ((24'h1 << wlen) - 24'h1);
        do_reset(f);
        cur_req = "R7";
        play_half(~left_lv, 5, 24'h5A5A5A & mask, wlen, fill);
        play_half(left_lv, slots, $urandom() & mask, wlen, fill);
        cur_req = req;
        for (int fr = 0; fr < frames; fr++) begin
            logic [23:0] lw = $urandom() & mask;
            logic [23:0] rw = $urandom() & mask;
            if (fr == 0) lw = (24'h1 << (wlen - 1)) | 24'h1;  // top bit set: negative in R4
            if (fr == 1) rw = mask >> 1;                       // top bit clear
            play_half(~left_lv, slots, rw, wlen, fill);
            play_half(left_lv, slots, lw, wlen, fill);
        end
        play_half(~left_lv, 3, 24'h0, wlen, fill);
    endtask

    initial begin
        do_reset(3'd0);
        // R1: reset state held with idle bit clock
        repeat (6) tick();
        run_case(3'd0, "R2", 32, 24, 1'b0, 3);
        run_case(3'd1, "R2", 32, 24, 1'b1, 2);
        run_case(3'd1, "R5", 32, 16, 1'b0, 2);   // short I2S word padded
        run_case(3'd0, "R5", 16, 24, 1'b0, 2);   // fewer slots than 24
        run_case(3'd2, "R3", 32, 24, 1'b1, 3);   // extra slots of ones ignored
        run_case(3'd7, "R3", 32, 20, 1'b0, 2);
        run_case(3'd2, "R5", 20, 24, 1'b0, 2);
        run_case(3'd3, "R4", 32, 24, 1'b1, 3);
        run_case(3'd4, "R4", 32, 20, 1'b1, 3);
        run_case(3'd5, "R4", 32, 18, 1'b1, 3);
        run_case(3'd6, "R4", 32, 16, 1'b1, 3);
        run_case(3'd6, "R6", 24, 16, 1'b0, 2);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R6 watchdog: actual run still busy, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule